// File: doc/BRIEF.md
# Soft Reset and Clock-Gate Controller

This block owns the per-peripheral control word that holds a guarded block in reset and stops its clock. Two bits of one 32-bit word matter: bit 31 requests a soft reset and bit 30 gates the clock. Software can write the whole word, or use set and clear strobes that touch only the bits marked in the write data. This lets a single bit change without a read-modify-write.

When the reset bit goes high, a sequencer drives a reset into the guarded block. The reset lasts at least a minimum number of cycles. If the request is still present after that, the hardware raises the clock-gate bit by itself. Software detects this by reading the word back. After the request is dropped, the readback copy of the reset bit stays high for a settle window before it reads low. The full release order is: clear reset, clear gate, set reset, wait for the gate to rise, clear reset, clear gate.

A configuration input suppresses every attempt to raise the reset bit. With it set, the release order reduces to the two clearing steps and the block is only enabled. At power-on both bits are set, so the guarded block starts gated and held in reset.

Top module: `rstgate_ctrl`

## Requirements
- R1: After `rst_ni` is released, and before any write, readback with `rd_i` high is 32'hC000_0000 (bit 31 reset, bit 30 gate). `blk_rst_o` is 1 and `clk_en_o` is 0.
- R2: A normal write (`wr_i`) loads bit 31 and bit 30 from `wdata_i`. All other bits are ignored and always read as 0.
- R3: A set write (`set_i`) raises each of bits 31 and 30 whose `wdata_i` bit is 1 and leaves the other bit unchanged.
- R4: A clear write (`clr_i`) lowers each of bits 31 and 30 whose `wdata_i` bit is 1 and leaves the other bit unchanged.
- R5: When more than one strobe is high in a cycle, the normal write wins over set, and set wins over clear.
- R6: `clk_en_o` is 0 exactly while the stored gate bit (bit 30) is 1, starting the cycle after the write that changes it.
- R7: After the reset bit is stored high, `blk_rst_o` rises one cycle later. It stays high for at least RST_MIN_CYC (3) cycles, even if software clears the bit sooner.
- R8: If the reset bit is still high when the minimum reset time has elapsed, the gate bit is forced to 1. While the reset is held, clear writes to the gate bit have no effect.
- R9: After `blk_rst_o` falls, bit 31 still reads 1 for SETTLE_CYC (3) cycles and then reads 0.
- R10: While `just_enable_i` is 1, any write that would raise bit 31 leaves it at 0, so no reset pulse occurs. Clearing both bits still works.
- R11: `rdata_o` is 0 whenever `rd_i` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| wr_i | input | 1 | Normal write strobe |
| set_i | input | 1 | Set-alias write strobe |
| clr_i | input | 1 | Clear-alias write strobe |
| wdata_i | input | 32 | Write data or bit mask |
| rd_i | input | 1 | Read enable |
| rdata_o | output | 32 | Readback word: bit 31 reset status, bit 30 gate |
| just_enable_i | input | 1 | Suppress raising of the reset bit |
| clk_en_o | output | 1 | Clock enable to the guarded block |
| blk_rst_o | output | 1 | Reset to the guarded block, active high |

## Verification
The properties assume `just_enable_i` changes only between writes. They also assume that a clear of the gate bit during a held reset is expected to be overridden, not rejected. The bench changes `just_enable_i` only when no strobe is active. It holds each strobe for exactly one cycle, with inputs settled well before the sampling edge. It also uses the multi-strobe cycles on purpose to exercise the priority order. All clears that race the sequencer are issued at known distances from the set, so each pulse length and gate-forcing edge can be predicted.

// File: rtl/rstgate_pkg.sv
`timescale 1ns/1ps
package rstgate_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE   = 2'd0,
    SEQ_PULSE  = 2'd1,
    SEQ_HOLD   = 2'd2,
    SEQ_SETTLE = 2'd3
  } seq_state_e;

  localparam int unsigned NUM_CTL = 2;  // index 0: reset bit, index 1: gate bit
  localparam int unsigned IDX_SRST = 0;
  localparam int unsigned IDX_GATE = 1;
endpackage

// File: rtl/rstgate_regs.sv
`timescale 1ns/1ps
module rstgate_regs
  import rstgate_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic               set_i,
  input  logic               clr_i,
  input  logic [NUM_CTL-1:0] wbits_i,
  input  logic               just_enable_i,
  input  logic               hw_gate_set_i,
  output logic [NUM_CTL-1:0] ctl_o
);
  logic [NUM_CTL-1:0] ctl_q, sw_nxt, ctl_nxt;

  always_comb begin
    if (wr_i)       sw_nxt = wbits_i;
    else if (set_i) sw_nxt = ctl_q | wbits_i;
    else if (clr_i) sw_nxt = ctl_q & ~wbits_i;
    else            sw_nxt = ctl_q;
  end

  // reset bit may fall but never rise in enable-only configuration
  assign ctl_nxt[IDX_SRST] = sw_nxt[IDX_SRST] & (ctl_q[IDX_SRST] | ~just_enable_i);
  // sequencer overrides software on the gate bit
  assign ctl_nxt[IDX_GATE] = sw_nxt[IDX_GATE] | hw_gate_set_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctl_q <= '1;
    else         ctl_q <= ctl_nxt;
  end

  assign ctl_o = ctl_q;
endmodule

// File: rtl/rstgate_seq.sv
`timescale 1ns/1ps
module rstgate_seq
  import rstgate_pkg::*;
#(
  parameter int unsigned RST_MIN_CYC = 3,
  parameter int unsigned SETTLE_CYC  = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic srst_i,
  output logic blk_rst_o,
  output logic hw_gate_set_o,
  output logic busy_o
);
  localparam int unsigned MAX_CYC = (RST_MIN_CYC > SETTLE_CYC) ? RST_MIN_CYC : SETTLE_CYC;
  localparam int unsigned CNT_W   = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);
  localparam logic [CNT_W-1:0] PULSE_LAST  = CNT_W'(RST_MIN_CYC - 1);
  localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(SETTLE_CYC - 1);

  seq_state_e       st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      SEQ_IDLE: if (srst_i) begin
        st_d  = SEQ_PULSE;
        cnt_d = '0;
      end
      SEQ_PULSE: begin
        if (cnt_q == PULSE_LAST) begin
          st_d  = srst_i ? SEQ_HOLD : SEQ_SETTLE;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      SEQ_HOLD: if (!srst_i) begin
        st_d  = SEQ_SETTLE;
        cnt_d = '0;
      end
      SEQ_SETTLE: begin
        if (srst_i) begin
          st_d  = SEQ_PULSE;
          cnt_d = '0;
        end else if (cnt_q == SETTLE_LAST) begin
          st_d  = SEQ_IDLE;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: begin
        st_d  = SEQ_HOLD;
        cnt_d = '0;
      end
    endcase
  end

  // power-on counts as a completed reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= SEQ_HOLD;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign blk_rst_o     = (st_q == SEQ_PULSE) || (st_q == SEQ_HOLD);
  assign hw_gate_set_o = (st_q == SEQ_HOLD);
  assign busy_o        = (st_q != SEQ_IDLE);
endmodule

// File: rtl/rstgate_ctrl.sv
`timescale 1ns/1ps
module rstgate_ctrl
  import rstgate_pkg::*;
#(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned SRST_BIT    = 31,
  parameter int unsigned GATE_BIT    = 30,
  parameter int unsigned RST_MIN_CYC = 3,
  parameter int unsigned SETTLE_CYC  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              set_i,
  input  logic              clr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              just_enable_i,
  output logic              clk_en_o,
  output logic              blk_rst_o
);
  logic [NUM_CTL-1:0] wbits, ctl;
  logic               hw_gate_set, seq_busy;
  logic               wdata_unused;

  for (genvar g = 0; g < NUM_CTL; g++) begin : g_pick
    localparam int unsigned POS = (g == IDX_SRST) ? SRST_BIT : GATE_BIT;
    assign wbits[g] = wdata_i[POS];
  end
  assign wdata_unused = ^wdata_i;

  rstgate_regs u_regs (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .wr_i          (wr_i),
    .set_i         (set_i),
    .clr_i         (clr_i),
    .wbits_i       (wbits),
    .just_enable_i (just_enable_i),
    .hw_gate_set_i (hw_gate_set),
    .ctl_o         (ctl)
  );

  rstgate_seq #(
    .RST_MIN_CYC (RST_MIN_CYC),
    .SETTLE_CYC  (SETTLE_CYC)
  ) u_seq (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .srst_i        (ctl[IDX_SRST]),
    .blk_rst_o     (blk_rst_o),
    .hw_gate_set_o (hw_gate_set),
    .busy_o        (seq_busy)
  );

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      rdata_o[SRST_BIT] = ctl[IDX_SRST] | seq_busy;
      rdata_o[GATE_BIT] = ctl[IDX_GATE];
    end
  end

  assign clk_en_o = ~ctl[IDX_GATE];
endmodule

// File: rtl/rstgate_chk.sv
`timescale 1ns/1ps
module rstgate_chk #(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned SRST_BIT    = 31,
  parameter int unsigned GATE_BIT    = 30,
  parameter int unsigned RST_MIN_CYC = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_i,
  input logic              set_i,
  input logic              clr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              rd_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              just_enable_i,
  input logic              blk_rst_o,
  input logic [1:0]        ctl,
  input logic              hw_gate_set,
  input logic              seq_busy
);
  int run_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        run_cnt <= int'(RST_MIN_CYC);
    else if (blk_rst_o) run_cnt <= (run_cnt < int'(RST_MIN_CYC)) ? run_cnt + 1 : run_cnt;
    else                run_cnt <= 0;
  end

  a_r7_min_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(blk_rst_o) |-> run_cnt >= int'(RST_MIN_CYC));

  a_r8_gate_forced: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw_gate_set |=> ctl[1]);

  a_r9_settle_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(blk_rst_o) |-> seq_busy);

  a_r10_no_raise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (just_enable_i && !ctl[0]) |=> !ctl[0]);

  a_r3_set_alias: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && !wr_i && !just_enable_i && wdata_i[SRST_BIT]) |=> ctl[0]);

  a_r4_clr_alias: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !wr_i && !set_i && !hw_gate_set && wdata_i[GATE_BIT]) |=> !ctl[1]);

  a_r5_write_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !wdata_i[SRST_BIT]) |=> !ctl[0]);

  a_r7_busy_readback: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blk_rst_o && rd_i) |-> rdata_o[SRST_BIT]);
endmodule

bind rstgate_ctrl rstgate_chk #(
  .DATA_W      (DATA_W),
  .SRST_BIT    (SRST_BIT),
  .GATE_BIT    (GATE_BIT),
  .RST_MIN_CYC (RST_MIN_CYC)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .wr_i          (wr_i),
  .set_i         (set_i),
  .clr_i         (clr_i),
  .wdata_i       (wdata_i),
  .rd_i          (rd_i),
  .rdata_o       (rdata_o),
  .just_enable_i (just_enable_i),
  .blk_rst_o     (blk_rst_o),
  .ctl           (ctl),
  .hw_gate_set   (hw_gate_set),
  .seq_busy      (seq_busy)
);

// File: tb/tb_rstgate_ctrl.sv
`timescale 1ns/1ps
module tb_rstgate_ctrl;
  localparam int MIN_C = 3;
  localparam int SET_C = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0, set = 1'b0, clr = 1'b0, rd = 1'b1, je = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        clk_en, blk_rst;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  rstgate_ctrl dut (
    .clk_i (clk), .rst_ni (rst_n), .wr_i (wr), .set_i (set), .clr_i (clr),
    .wdata_i (wdata), .rd_i (rd), .rdata_o (rdata), .just_enable_i (je),
    .clk_en_o (clk_en), .blk_rst_o (blk_rst)
  );

  // behavioural reference: stored bits, reset-active flag, age and settle countdown
  bit m_srst = 1'b1, m_gate = 1'b1, m_blk = 1'b1;
  int m_age = MIN_C, m_settle = 0;
  bit n_srst, n_gate, force_g;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_srst = 1'b1; m_gate = 1'b1; m_blk = 1'b1; m_age = MIN_C; m_settle = 0;
    end else begin
      force_g = m_blk && (m_age >= MIN_C);
      n_srst = m_srst; n_gate = m_gate;
      if (wr) begin n_srst = wdata[31]; n_gate = wdata[30]; end
      else if (set) begin n_srst = m_srst | wdata[31]; n_gate = m_gate | wdata[30]; end
      else if (clr) begin n_srst = m_srst & ~wdata[31]; n_gate = m_gate & ~wdata[30]; end
      if (je && !m_srst) n_srst = 1'b0;
      if (force_g) n_gate = 1'b1;
      if (m_blk) begin
        if (m_age < MIN_C) begin
          m_age++;
          if (m_age == MIN_C && !m_srst) begin m_blk = 1'b0; m_settle = SET_C; end
        end else if (!m_srst) begin
          m_blk = 1'b0; m_settle = SET_C;
        end
      end else if (m_settle > 0) begin
        if (m_srst) begin m_blk = 1'b1; m_age = 0; m_settle = 0; end
        else m_settle--;
      end else if (m_srst) begin
        m_blk = 1'b1; m_age = 0;
      end
      m_srst = n_srst; m_gate = n_gate;
    end
  end

  function automatic logic [31:0] model_rd();
    logic [31:0] v = '0;
    if (rd) begin
      v[31] = m_srst || m_blk || (m_settle > 0);
      v[30] = m_gate;
    end
    return v;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R7 blk_rst_o", {31'b0, blk_rst}, {31'b0, m_blk});
      chk("R6 clk_en_o", {31'b0, clk_en}, {31'b0, ~m_gate});
      chk("R2 rdata_o", rdata, model_rd());
    end
  end

  task automatic bus(bit w, bit s, bit c, logic [31:0] d);
    @(posedge clk); #2;
    wr = w; set = s; clr = c; wdata = d;
    @(posedge clk); #2;
    wr = 1'b0; set = 1'b0; clr = 1'b0; wdata = '0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #2; end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      done = 1'b1;
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    // R1 power-on state
    chk("R1 rdata", rdata, 32'hC000_0000);
    chk("R1 blk_rst_o", {31'b0, blk_rst}, 32'd1);
    chk("R1 clk_en_o", {31'b0, clk_en}, 32'd0);

    // release reset bit: R9 settle window then R4 clear only reset bit
    bus(0, 0, 1, 32'h8000_0000);
    chk("R9 still busy", {31'b0, rdata[31]}, 32'd1);
    idle(1);
    chk("R9 blk released", {31'b0, blk_rst}, 32'd0);
    chk("R9 readback high in settle", {31'b0, rdata[31]}, 32'd1);
    idle(3);
    chk("R4 only reset cleared", rdata, 32'h4000_0000);
    bus(0, 0, 1, 32'h4000_0000);
    chk("R6 clock enabled", {31'b0, clk_en}, 32'd1);
    chk("R4 gate cleared", rdata, 32'h0);

    // R2 other bits ignored
    bus(1, 0, 0, 32'h3FFF_FFFF);
    chk("R2 ignored bits", rdata, 32'h0);
    // R3 set alias only marked bit
    bus(0, 1, 0, 32'h4000_0000);
    chk("R3 set gate only", rdata, 32'h4000_0000);
    chk("R6 clock stopped", {31'b0, clk_en}, 32'd0);
    bus(1, 0, 0, 32'h0);

    // R7 early clear keeps minimum pulse, no gate forcing
    bus(0, 1, 0, 32'h8000_0000);
    bus(0, 0, 1, 32'h8000_0000);
    idle(1);
    chk("R7 pulse held after early clear", {31'b0, blk_rst}, 32'd1);
    idle(1);
    chk("R7 pulse ended", {31'b0, blk_rst}, 32'd0);
    idle(5);
    chk("R8 no forcing on short request", {31'b0, clk_en}, 32'd1);

    // R8 held reset forces gate; clear of gate ignored
    bus(0, 1, 0, 32'h8000_0000);
    idle(6);
    chk("R8 gate forced", rdata, 32'hC000_0000);
    bus(0, 0, 1, 32'h4000_0000);
    idle(1);
    chk("R8 gate clear ignored", rdata, 32'hC000_0000);
    chk("R8 clock still stopped", {31'b0, clk_en}, 32'd0);
    bus(0, 0, 1, 32'h8000_0000);
    idle(6);
    bus(0, 0, 1, 32'h4000_0000);
    chk("R8 release done", rdata, 32'h0);

    // R5 priority
    bus(1, 1, 1, 32'h4000_0000);
    chk("R5 write over set and clear", rdata, 32'h4000_0000);
    idle(5);
    bus(0, 1, 1, 32'h4000_0000);
    chk("R5 set over clear", rdata, 32'h4000_0000);
    bus(0, 0, 1, 32'h4000_0000);
    chk("R5 clear alone", rdata, 32'h0);

    // R10 enable-only configuration
    idle(5);
    je = 1'b1;
    bus(0, 1, 0, 32'h8000_0000);
    idle(3);
    chk("R10 no reset pulse", {31'b0, blk_rst}, 32'd0);
    chk("R10 reset bit stays low", rdata, 32'h0);
    bus(1, 0, 0, 32'hC000_0000);
    chk("R10 write raises gate only", rdata, 32'h4000_0000);
    bus(0, 0, 1, 32'h4000_0000);
    je = 1'b0;
    bus(0, 1, 0, 32'h8000_0000);
    idle(6);
    je = 1'b1;
    bus(0, 0, 1, 32'h8000_0000);
    idle(5);
    bus(0, 0, 1, 32'h4000_0000);
    chk("R10 clears still work", rdata, 32'h0);
    chk("R10 clock enabled", {31'b0, clk_en}, 32'd1);
    je = 1'b0;

    // R11 read enable low
    bus(0, 1, 0, 32'h4000_0000);
    rd = 1'b0;
    #1;
    chk("R11 rdata zero without read", rdata, 32'h0);
    idle(1);
    rd = 1'b1;
    bus(0, 0, 1, 32'h4000_0000);
    idle(2);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule